// File: doc/BRIEF.md
# Stop-Mode Wake Event Logic

This block decides when a sleeping microcontroller should wake. It watches two input ports, an 8-pin port A and a 4-pin port B, together with their output-direction masks. Four groups of sources, each set up through a small register file, can raise the wake event. The first is a primary level selector. It tests one port-B pin, or a reduction over the port-A pins, against a programmed polarity. The second is a secondary selector with seven fixed AND/OR/NAND/NOR terms. The third and fourth are per-pin change detectors. They compare each enabled pin with a snapshot of that port, taken when software last read or wrote it.

The combined event can also be steered onto interrupt line 1. While it is steered there and an event is present, port-B pin 3 reads back as 0, so software can tell a wake interrupt from other causes. A status register reports, for each port, whether a snapshot exists and whether the latest snapshot came from a port write or a port read. All register and snapshot updates happen on the rising clock edge. The wake event itself is combinational from the registers and the live pins.

Top module: `wake_evt_top`

## Requirements
- R1: After synchronous reset every register reads 0, `wake_evt` is low and `irq1` is low.
- R2: Primary select codes 0 (none) and 1 (reserved) never produce an event, whatever the pins and the polarity.
- R3: Register 0 holds the primary polarity in bit 6 and the select in bits 4:2. The codes are: 2 = port-B pin 1, 3 = port-B pin 2, 4 = port-B pin 3, 5 = AND of port-A pins, 6 = OR of port-A pins, 7 = XOR of port-A pins. An event occurs when the selected value equals the polarity.
- R4: The primary selector leaves out every pin that is an output (direction bit 1) or is enabled for change detection. A single-pin mode on an excluded pin gives no event. A port-A reduction covers only the eligible pins and gives no event when none are eligible.
- R5: Register 1 enables port-A pins for change detection. An enabled pin raises an event while it differs from the port-A snapshot. No change event occurs before the first snapshot.
- R6: A port read strobe snapshots the live pins. A port write strobe snapshots the write data. When both strobes arrive in the same cycle, the write data is taken.
- R7: Register 3 (bits 3:0) enables port-B pins for change detection against the port-B snapshot, with the same rules as R5 and R6.
- R8: Register 2 holds the secondary level in bit 7 and the code in bits 2:0. The codes are: 1 = AND of A[3:0], 2 = OR of A[7:4], 3 = NAND of B[3:0], 4 = NOR of B[3:0], 5 = A0 AND B0, 6 = A7 OR B3, 7 = NAND of A1, A0, B1 and B0. Code 0 gives no event. An event occurs when the term equals the level.
- R9: `wake_evt` is the OR of the primary, secondary, port-A change and port-B change events.
- R10: With register 4 bit 4 set, `irq1` follows `wake_evt`, and `pb_rd_view` bit 3 reads 0 while `wake_evt` is high. Otherwise `irq1` is 0 and `pb_rd_view` equals the port-B pins.
- R11: Register 4 reports status in bits 0 to 3: bit 0 = port-A snapshot taken, bit 1 = the last port-A snapshot came from a write, bit 2 = port-B snapshot taken, bit 3 = the last port-B snapshot came from a write. Register writes cannot change these bits.
- R12: Bits a register does not implement read back as 0. Register addresses above 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| pa_pin | input | 8 | Port-A pin levels |
| pa_dir_out | input | 8 | Port-A direction, 1 = output |
| pa_rd | input | 1 | Software read of port A (snapshot pins) |
| pa_wr | input | 1 | Software write of port A (snapshot data) |
| pa_wdata | input | 8 | Data written to port A |
| pb_pin | input | 4 | Port-B pin levels |
| pb_dir_out | input | 4 | Port-B direction, 1 = output |
| pb_rd | input | 1 | Software read of port B |
| pb_wr | input | 1 | Software write of port B |
| pb_wdata | input | 4 | Data written to port B |
| wake_evt | output | 1 | Combined wake event |
| irq1 | output | 1 | Wake event routed to interrupt line 1 |
| pb_rd_view | output | 4 | Port-B value as software reads it |

## Verification
The hardest state to reach from the ports is a change detector comparing against a snapshot that came from write data while the live pins show something else. The read-versus-write priority is the hardest case of all. The bench raises both strobes in one cycle with pins and write data set to opposite values, then moves the pins. It can then tell from the wake output which value was captured. The exclusion rules are reached before any snapshot exists. Enabling change detection at that point only masks pins from the primary selector and adds no change events of its own.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int PA_W   = 8;
    localparam int PB_W   = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_PRIM  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_AEN   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_SEC   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_BEN   = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_ROUTE = 3'd4;

    localparam int ROUTE_BIT = 4;

    typedef enum logic [2:0] {
        PS_NONE = 3'd0,
        PS_RSVD = 3'd1,
        PS_B1   = 3'd2,
        PS_B2   = 3'd3,
        PS_B3   = 3'd4,
        PS_AAND = 3'd5,
        PS_AOR  = 3'd6,
        PS_AXOR = 3'd7
    } prim_sel_e;

    typedef enum logic [2:0] {
        SS_NONE       = 3'd0,
        SS_ALO_AND    = 3'd1,
        SS_AHI_OR     = 3'd2,
        SS_B_NAND     = 3'd3,
        SS_B_NOR      = 3'd4,
        SS_AB0_AND    = 3'd5,
        SS_ABTOP_OR   = 3'd6,
        SS_ABLO_NAND  = 3'd7
    } sec_sel_e;

    typedef struct packed {
        logic      pol;
        prim_sel_e sel;
    } prim_cfg_t;

    typedef struct packed {
        logic     lvl;
        sec_sel_e sel;
    } sec_cfg_t;

    typedef struct packed {
        logic b_wr;
        logic b_vld;
        logic a_wr;
        logic a_vld;
    } snap_stat_t;

    // Returns {valid, value}; valid is low when the chosen source has no eligible pin.
    function automatic logic [1:0] prim_eval(
        input prim_sel_e       sel,
        input logic [PA_W-1:0] pa,
        input logic [PA_W-1:0] pa_ok,
        input logic [PB_W-1:0] pb,
        input logic [PB_W-1:0] pb_ok
    );
        logic v;
        logic r;
        v = 1'b0;
        r = 1'b0;
        case (sel)
            PS_B1:   begin v = pb_ok[1]; r = pb[1]; end
            PS_B2:   begin v = pb_ok[2]; r = pb[2]; end
            PS_B3:   begin v = pb_ok[3]; r = pb[3]; end
            PS_AAND: begin v = |pa_ok;   r = &(pa | ~pa_ok); end
            PS_AOR:  begin v = |pa_ok;   r = |(pa & pa_ok); end
            PS_AXOR: begin v = |pa_ok;   r = ^(pa & pa_ok); end
            default: begin v = 1'b0;     r = 1'b0; end
        endcase
        return {v, r};
    endfunction

    function automatic logic sec_eval(
        input sec_sel_e        sel,
        input logic [PA_W-1:0] pa,
        input logic [PB_W-1:0] pb
    );
        logic r;
        case (sel)
            SS_ALO_AND:   r = &pa[3:0];
            SS_AHI_OR:    r = |pa[7:4];
            SS_B_NAND:    r = ~&pb[3:0];
            SS_B_NOR:     r = ~|pb[3:0];
            SS_AB0_AND:   r = pa[0] & pb[0];
            SS_ABTOP_OR:  r = pa[7] | pb[3];
            SS_ABLO_NAND: r = ~&{pa[1:0], pb[1:0]};
            default:      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int AW = PA_W,
    parameter int BW = PB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  snap_stat_t         stat,
    output prim_cfg_t          prim_cfg,
    output sec_cfg_t           sec_cfg,
    output logic [AW-1:0]      a_en,
    output logic [BW-1:0]      b_en,
    output logic               route_en,
    output logic [DATA_W-1:0]  rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_cfg <= '{pol: 1'b0, sel: PS_NONE};
            sec_cfg  <= '{lvl: 1'b0, sel: SS_NONE};
            a_en     <= '0;
            b_en     <= '0;
            route_en <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                ADDR_PRIM: begin
                    prim_cfg.pol <= wdata[6];
                    prim_cfg.sel <= prim_sel_e'(wdata[4:2]);
                end
                ADDR_AEN:   a_en <= wdata[AW-1:0];
                ADDR_SEC: begin
                    sec_cfg.lvl <= wdata[7];
                    sec_cfg.sel <= sec_sel_e'(wdata[2:0]);
                end
                ADDR_BEN:   b_en <= wdata[BW-1:0];
                ADDR_ROUTE: route_en <= wdata[ROUTE_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_PRIM:  rdata = {1'b0, prim_cfg.pol, 1'b0, prim_cfg.sel, 2'b00};
            ADDR_AEN:   rdata = DATA_W'(a_en);
            ADDR_SEC:   rdata = {sec_cfg.lvl, 4'b0000, sec_cfg.sel};
            ADDR_BEN:   rdata = DATA_W'(b_en);
            ADDR_ROUTE: rdata = {3'b000, route_en, stat};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/wake_snap.sv
module wake_snap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         port_rd,
    input  logic         port_wr,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] en,
    output logic         vld,
    output logic         by_wr,
    output logic         chg_evt
);

    logic [W-1:0] snap_q;
    logic [W-1:0] chg_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            vld    <= 1'b0;
            by_wr  <= 1'b0;
        end else if (port_wr) begin
            snap_q <= wdata;
            vld    <= 1'b1;
            by_wr  <= 1'b1;
        end else if (port_rd) begin
            snap_q <= pin;
            vld    <= 1'b1;
            by_wr  <= 1'b0;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign chg_bits[i] = en[i] & vld & (pin[i] ^ snap_q[i]);
    end

    assign chg_evt = |chg_bits;

endmodule

// File: rtl/wake_levels.sv
module wake_levels
    import wake_pkg::*;
(
    input  prim_cfg_t        prim_cfg,
    input  sec_cfg_t         sec_cfg,
    input  logic [PA_W-1:0]  pa,
    input  logic [PA_W-1:0]  pa_excl,
    input  logic [PB_W-1:0]  pb,
    input  logic [PB_W-1:0]  pb_excl,
    output logic             prim_evt,
    output logic             sec_evt
);

    logic [1:0] prim_res;
    logic       sec_res;

    always_comb begin
        prim_res = prim_eval(prim_cfg.sel, pa, ~pa_excl, pb, ~pb_excl);
        prim_evt = prim_res[1] & (prim_res[0] == prim_cfg.pol);
        sec_res  = sec_eval(sec_cfg.sel, pa, pb);
        sec_evt  = (sec_cfg.sel != SS_NONE) & (sec_res == sec_cfg.lvl);
    end

endmodule

// File: rtl/wake_evt_top.sv
module wake_evt_top
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        pa_pin,
    input  logic [7:0]        pa_dir_out,
    input  logic              pa_rd,
    input  logic              pa_wr,
    input  logic [7:0]        pa_wdata,
    input  logic [3:0]        pb_pin,
    input  logic [3:0]        pb_dir_out,
    input  logic              pb_rd,
    input  logic              pb_wr,
    input  logic [3:0]        pb_wdata,
    output logic              wake_evt,
    output logic              irq1,
    output logic [3:0]        pb_rd_view
);

    prim_cfg_t        prim_cfg;
    sec_cfg_t         sec_cfg;
    logic [PA_W-1:0]  a_en;
    logic [PB_W-1:0]  b_en;
    logic             route_en;
    snap_stat_t       snap_stat;
    logic             a_chg;
    logic             b_chg;
    logic             prim_evt;
    logic             sec_evt;

    wake_regs #(.AW(PA_W), .BW(PB_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .stat     (snap_stat),
        .prim_cfg (prim_cfg),
        .sec_cfg  (sec_cfg),
        .a_en     (a_en),
        .b_en     (b_en),
        .route_en (route_en),
        .rdata    (reg_rdata)
    );

    wake_snap #(.W(PA_W)) u_snap_a (
        .clk     (clk),
        .rst     (rst),
        .port_rd (pa_rd),
        .port_wr (pa_wr),
        .pin     (pa_pin),
        .wdata   (pa_wdata),
        .en      (a_en),
        .vld     (snap_stat.a_vld),
        .by_wr   (snap_stat.a_wr),
        .chg_evt (a_chg)
    );

    wake_snap #(.W(PB_W)) u_snap_b (
        .clk     (clk),
        .rst     (rst),
        .port_rd (pb_rd),
        .port_wr (pb_wr),
        .pin     (pb_pin),
        .wdata   (pb_wdata),
        .en      (b_en),
        .vld     (snap_stat.b_vld),
        .by_wr   (snap_stat.b_wr),
        .chg_evt (b_chg)
    );

    wake_levels u_levels (
        .prim_cfg (prim_cfg),
        .sec_cfg  (sec_cfg),
        .pa       (pa_pin),
        .pa_excl  (pa_dir_out | a_en),
        .pb       (pb_pin),
        .pb_excl  (pb_dir_out | b_en),
        .prim_evt (prim_evt),
        .sec_evt  (sec_evt)
    );

    assign wake_evt = prim_evt | sec_evt | a_chg | b_chg;
    assign irq1     = route_en & wake_evt;

    always_comb begin
        pb_rd_view    = pb_pin;
        pb_rd_view[3] = pb_pin[3] & ~(route_en & wake_evt);
    end

endmodule

// File: rtl/wake_chk.sv
module wake_chk
    import wake_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pa_wr,
    input logic             pb_wr,
    input logic             wake_evt,
    input logic             irq1,
    input logic             view_b3,
    input logic             route_en,
    input snap_stat_t       snap_stat,
    input logic [2:0]       prim_sel,
    input logic [2:0]       sec_sel,
    input logic [PA_W-1:0]  a_en,
    input logic [PB_W-1:0]  b_en
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wake_evt && !irq1));  // R1

    AST_NO_SOURCE_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (prim_sel <= 3'd1 && sec_sel == 3'd0 && a_en == '0 && b_en == '0) |-> !wake_evt);  // R2

    AST_IRQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (rst)
        irq1 |-> (wake_evt && route_en));  // R10

    AST_PB3_READS_LOW: assert property (@(posedge clk) disable iff (rst)
        (route_en && wake_evt) |-> !view_b3);  // R10

    AST_A_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        pa_wr |=> (snap_stat.a_vld && snap_stat.a_wr));  // R6

    AST_B_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        pb_wr |=> (snap_stat.b_vld && snap_stat.b_wr));  // R7

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(snap_stat.a_vld) && !$past(rst)) |-> snap_stat.a_vld);  // R11

endmodule

bind wake_evt_top wake_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pa_wr     (pa_wr),
    .pb_wr     (pb_wr),
    .wake_evt  (wake_evt),
    .irq1      (irq1),
    .view_b3   (pb_rd_view[3]),
    .route_en  (route_en),
    .snap_stat (snap_stat),
    .prim_sel  (prim_cfg.sel),
    .sec_sel   (sec_cfg.sel),
    .a_en      (a_en),
    .b_en      (b_en)
);

// File: tb/wake_evt_top_tb_top.sv
module wake_evt_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pa_pin = '0;
    logic [7:0] pa_dir_out = '0;
    logic       pa_rd = 1'b0;
    logic       pa_wr = 1'b0;
    logic [7:0] pa_wdata = '0;
    logic [3:0] pb_pin = '0;
    logic [3:0] pb_dir_out = '0;
    logic       pb_rd = 1'b0;
    logic       pb_wr = 1'b0;
    logic [3:0] pb_wdata = '0;
    logic       wake_evt;
    logic       irq1;
    logic [3:0] pb_rd_view;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] pa_pat [6] = '{8'h00, 8'hFF, 8'h5A, 8'h01, 8'h80, 8'h3C};
    logic [3:0] pb_pat [6] = '{4'h0, 4'hF, 4'h2, 4'h4, 4'h8, 4'hA};

    always #2.5 clk = ~clk;

    wake_evt_top dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pa_pin(pa_pin), .pa_dir_out(pa_dir_out), .pa_rd(pa_rd), .pa_wr(pa_wr), .pa_wdata(pa_wdata),
        .pb_pin(pb_pin), .pb_dir_out(pb_dir_out), .pb_rd(pb_rd), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
        .wake_evt(wake_evt), .irq1(irq1), .pb_rd_view(pb_rd_view)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pins(input logic [7:0] a, input logic [3:0] b);
        @(negedge clk);
        pa_pin = a; pb_pin = b;
        #1;
    endtask

    task automatic strobe(input bit a_rd, input bit a_wr, input logic [7:0] a_d,
                          input bit b_rd, input bit b_wr, input logic [3:0] b_d);
        @(negedge clk);
        pa_rd = a_rd; pa_wr = a_wr; pa_wdata = a_d;
        pb_rd = b_rd; pb_wr = b_wr; pb_wdata = b_d;
        @(negedge clk);
        pa_rd = 1'b0; pa_wr = 1'b0; pb_rd = 1'b0; pb_wr = 1'b0;
    endtask

    function automatic bit prim_ref(int code, bit pol, bit [7:0] pa, bit [3:0] pb,
                                    bit [7:0] a_excl, bit [3:0] b_excl);
        bit r;
        int n;
        if (code >= 2 && code <= 4) begin
            if (b_excl[code-1]) return 1'b0;
            return pb[code-1] == pol;
        end
        if (code < 5) return 1'b0;
        n = 0;
        r = (code == 5);
        for (int i = 0; i < 8; i++) begin
            if (!a_excl[i]) begin
                n++;
                if (code == 5) r = r & pa[i];
                else if (code == 6) r = r | pa[i];
                else r = r ^ pa[i];
            end
        end
        if (n == 0) return 1'b0;
        return r == pol;
    endfunction

    function automatic bit sec_ref(int code, bit lvl, bit [7:0] pa, bit [3:0] pb);
        bit t;
        case (code)
            1: t = pa[0] && pa[1] && pa[2] && pa[3];
            2: t = pa[4] || pa[5] || pa[6] || pa[7];
            3: t = !(pb == 4'hF);
            4: t = (pb == 4'h0);
            5: t = pa[0] && pb[0];
            6: t = pa[7] || pb[3];
            7: t = !(pa[0] && pa[1] && pb[0] && pb[1]);
            default: return 1'b0;
        endcase
        return t == lvl;
    endfunction

    // R1, R12, R11: reset values, implemented-bit masks, read-only status
    task automatic t_reset_and_regs();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1", $sformatf("reg %0d after reset", a), d, 0);
        end
        chk("R1", "wake after reset", wake_evt, 0);
        chk("R1", "irq1 after reset", irq1, 0);
        for (int a = 0; a < 8; a++) wr(3'(a), 8'hFF);
        rd(3'd0, d); chk("R12", "reg0 mask", d, 8'h5C);
        rd(3'd1, d); chk("R12", "reg1 mask", d, 8'hFF);
        rd(3'd2, d); chk("R12", "reg2 mask", d, 8'h87);
        rd(3'd3, d); chk("R12", "reg3 mask", d, 8'h0F);
        rd(3'd4, d); chk("R11", "reg4 status not writable", d, 8'h10);
        rd(3'd6, d); chk("R12", "unmapped address", d, 8'h00);
        for (int a = 0; a < 5; a++) wr(3'(a), 8'h00);
    endtask

    task automatic run_prim(input string req, input logic [7:0] adir, input logic [7:0] aen,
                            input logic [3:0] bdir, input logic [3:0] ben);
        wr(3'd1, aen);
        wr(3'd3, {4'h0, ben});
        pa_dir_out = adir;
        pb_dir_out = bdir;
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 2; p++) begin
                wr(3'd0, {1'b0, p[0], 1'b0, c[2:0], 2'b00});
                for (int k = 0; k < 6; k++) begin
                    pins(pa_pat[k], pb_pat[k]);
                    chk(c < 2 ? "R2" : req, $sformatf("primary code %0d pol %0d pat %0d", c, p, k),
                        wake_evt, prim_ref(c, p[0], pa_pat[k], pb_pat[k], adir | aen, bdir | ben));
                end
            end
        end
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h00);
        pa_dir_out = '0;
        pb_dir_out = '0;
    endtask

    // R2, R3
    task automatic t_primary();
        run_prim("R3", 8'h00, 8'h00, 4'h0, 4'h0);
    endtask

    // R4: exclusions by direction and by change enable (no snapshot yet, so no change events)
    task automatic t_exclude();
        run_prim("R4", 8'h81, 8'h10, 4'h2, 4'h8);
        run_prim("R4", 8'hF0, 8'h0F, 4'hC, 4'h2);
    endtask

    // R8
    task automatic t_secondary();
        for (int c = 0; c < 8; c++) begin
            for (int l = 0; l < 2; l++) begin
                wr(3'd2, {l[0], 4'h0, c[2:0]});
                for (int k = 0; k < 6; k++) begin
                    pins(pa_pat[k], pb_pat[(k + 2) % 6]);
                    chk("R8", $sformatf("secondary code %0d lvl %0d pat %0d", c, l, k),
                        wake_evt, sec_ref(c, l[0], pa_pat[k], pb_pat[(k + 2) % 6]));
                end
            end
        end
        wr(3'd2, 8'h00);
    endtask

    // R5, R6, R11 on port A
    task automatic t_change_a();
        logic [7:0] d;
        wr(3'd1, 8'h0C);
        pins(8'h04, 4'h0);
        chk("R5", "no change event before snapshot", wake_evt, 0);
        strobe(1, 0, 8'hAA, 0, 0, 4'h0);
        rd(3'd4, d); chk("R11", "A latched by read", d, 8'h01);
        chk("R6", "read snapshot matches pins", wake_evt, 0);
        pins(8'h0C, 4'h0); chk("R5", "enabled pin 3 changed", wake_evt, 1);
        pins(8'h05, 4'h0); chk("R5", "only disabled pin changed", wake_evt, 0);
        strobe(0, 1, 8'h08, 0, 0, 4'h0);
        rd(3'd4, d); chk("R11", "A latched by write", d, 8'h03);
        chk("R6", "write snapshot differs from pins", wake_evt, 1);
        pins(8'h08, 4'h0); chk("R6", "pins equal written data", wake_evt, 0);
        pins(8'hFF, 4'h0);
        strobe(1, 1, 8'h00, 0, 0, 4'h0);
        pins(8'h00, 4'h0); chk("R6", "write wins over read", wake_evt, 0);
        pins(8'h04, 4'h0); chk("R6", "change against written zero", wake_evt, 1);
        pins(8'h00, 4'h0);
        rd(3'd4, d); chk("R11", "A flags after simultaneous strobes", d, 8'h03);
    endtask

    // R7, R11 on port B
    task automatic t_change_b();
        logic [7:0] d;
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h03);
        pins(8'h00, 4'h1);
        chk("R7", "B no event before snapshot", wake_evt, 0);
        strobe(0, 0, 8'h00, 1, 0, 4'h0);
        rd(3'd4, d); chk("R11", "B latched by read", d, 8'h07);
        chk("R7", "B read snapshot matches", wake_evt, 0);
        pins(8'h00, 4'h3); chk("R7", "B enabled pin 1 changed", wake_evt, 1);
        pins(8'h00, 4'h5); chk("R7", "B only disabled pin changed", wake_evt, 0);
        strobe(0, 0, 8'h00, 0, 1, 4'h2);
        rd(3'd4, d); chk("R11", "B latched by write", d, 8'h0F);
        chk("R7", "B pins differ from written data", wake_evt, 1);
        pins(8'h00, 4'h2); chk("R7", "B pins equal written data", wake_evt, 0);
    endtask

    // R9: each source alone drives the combined event
    task automatic t_combine();
        wr(3'd1, 8'h80);
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h4C);
        wr(3'd2, 8'h81);
        pins(8'h00, 4'h2); chk("R9", "all sources quiet", wake_evt, 0);
        pins(8'h00, 4'h6); chk("R9", "primary only", wake_evt, 1);
        pins(8'h0F, 4'h2); chk("R9", "secondary only", wake_evt, 1);
        pins(8'h80, 4'h2); chk("R9", "port A change only", wake_evt, 1);
        pins(8'h00, 4'h3); chk("R9", "port B change only", wake_evt, 1);
    endtask

    // R10
    task automatic t_route();
        wr(3'd4, 8'h10);
        pins(8'h00, 4'h2);
        chk("R10", "routed, no event: irq1", irq1, 0);
        chk("R10", "routed, no event: view", pb_rd_view, 4'h2);
        pins(8'h00, 4'hE);
        chk("R10", "routed event: irq1", irq1, 1);
        chk("R10", "routed event: pin 3 reads 0", pb_rd_view, 4'h6);
        wr(3'd4, 8'h00);
        #1;
        chk("R10", "unrouted event: irq1", irq1, 0);
        chk("R10", "unrouted event: view", pb_rd_view, 4'hE);
        chk("R10", "unrouted event still wakes", wake_evt, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_and_regs();
        t_primary();
        t_exclude();
        t_secondary();
        t_change_a();
        t_change_b();
        t_combine();
        t_route();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule